// File: doc/BRIEF.md
# Waveform ID Playback Sequencer

The sequencer holds a short queue of 8-bit slots and, once started, walks through them in order from the first slot. Each slot either names a stored waveform (bit 7 clear, bits [6:0] the identifier 1..127) or asks for a pause (bit 7 set, bits [6:0] a count of 10 ms units). A waveform slot becomes a play request to an external playback engine. The engine acknowledges completion with a single-cycle done pulse. A pause slot is timed with a 1 ms tick, which a prescaler derives from the system clock. The walk ends at the first all-zero slot or after the last slot, and the start flag then drops back to zero by itself.

Software loads the slots and the start flag through a simple write port. It reads them back through a combinational read port. Slots live at addresses 0x04..0x0B, with slot 0 at 0x04. The start/abort flag is bit 0 of address 0x0C. Clearing the flag mid-run abandons the sequence at once.

Top module: `wave_seq`

## Requirements
- R1: A write to address 0x04+k (k = 0..7) stores the 8-bit value in slot k, and a read of that address returns it. Writes to any other address except 0x0C change no slot and start nothing.
- R2: Writing 1 to bit 0 of address 0x0C while idle starts the run at slot 0. Bit 0 of a read at 0x0C returns 1 while the run is in progress and 0 once it has ended.
- R3: A slot with bit 7 = 0 and a nonzero value raises play_req_o with play_id_o = slot[6:0]. Both are held steady until play_done_i is seen high.
- R4: After a done pulse the sequencer moves to the next slot. The run ends at the first slot equal to 0x00, and no later slot is played.
- R5: When all eight slots are nonzero, all eight are processed in order, and the run ends after slot 7.
- R6: A slot with bit 7 = 1 and u = slot[6:0] > 0 issues no request for u × 10 × CLK_PER_MS clock cycles. Only then does the next slot proceed.
- R7: The slot value 0x80 (a pause of zero length) costs no wait time and does not end the run. The next slot is fetched on the following cycle.
- R8: Writing 0 to bit 0 of 0x0C during a run aborts it. From the next cycle play_req_o is low and the flag reads 0.
- R9: Writing 1 to bit 0 of 0x0C during a run has no effect. The current request and its identifier are kept.
- R10: After reset, play_req_o is low, the flag reads 0 and all slots read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | 8 | Read data for rd_addr_i (combinational) |
| play_req_o | output | 1 | Play request to the playback engine |
| play_id_o | output | 7 | Waveform identifier for the request |
| play_done_i | input | 1 | One-cycle completion pulse from the engine |

## Verification
The assertions check four things on every cycle: the request and identifier stay steady while no done pulse arrives, the identifier is never zero, a start write always enters the run, and an abort drops the request on the next cycle. A start write during a run that does not cut the request short is also checked every cycle. Only the bench's scenarios can show some results. These are the order in which slots are played, the early end at a zero slot, the full eight-slot walk, and the exact length of pauses, including the zero-length pause. The bench compares the observed identifier list and the idle gaps in front of each request with a model of the slot walk.

// File: rtl/wave_seq_pkg.sv
package wave_seq_pkg;
  localparam int unsigned SLOT_W = 8;
  localparam int unsigned ID_W   = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_PLAY,
    ST_WAIT
  } seq_state_e;
endpackage

// File: rtl/wave_seq_regs.sv
module wave_seq_regs
  import wave_seq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned SLOT_BASE = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [ADDR_W-1:0]                  wr_addr_i,
  input  logic [SLOT_W-1:0]                  wr_data_i,
  input  logic [ADDR_W-1:0]                  rd_addr_i,
  input  logic                               busy_i,
  output logic [SLOT_W-1:0]                  rd_data_o,
  output logic [NUM_SLOTS-1:0][SLOT_W-1:0]   slots_o,
  output logic                               start_o,
  output logic                               abort_o
);
  localparam int unsigned GO_ADDR = SLOT_BASE + NUM_SLOTS;

  logic go_hit;
  assign go_hit  = wr_en_i && (wr_addr_i == ADDR_W'(GO_ADDR));
  assign start_o = go_hit && wr_data_i[0] && !busy_i;
  assign abort_o = go_hit && !wr_data_i[0] && busy_i;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == ADDR_W'(SLOT_BASE + g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  slots_o[g] <= '0;
      else if (hit) slots_o[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rd_addr_i == ADDR_W'(SLOT_BASE + i)) rd_data_o = slots_o[i];
    end
    if (rd_addr_i == ADDR_W'(GO_ADDR)) rd_data_o = {{(SLOT_W-1){1'b0}}, busy_i};
  end
endmodule

// File: rtl/wave_seq_tick.sv
module wave_seq_tick #(
  parameter int unsigned CLK_PER_MS = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(CLK_PER_MS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/wave_seq_fsm.sv
module wave_seq_fsm
  import wave_seq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS      = 8,
  parameter int unsigned TICKS_PER_UNIT = 10
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_SLOTS-1:0][SLOT_W-1:0]  slots_i,
  input  logic                              start_i,
  input  logic                              abort_i,
  input  logic                              tick_i,
  input  logic                              play_done_i,
  output logic                              tick_clr_o,
  output logic                              play_req_o,
  output logic [ID_W-1:0]                   play_id_o,
  output logic                              busy_o
);
  localparam int unsigned IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int unsigned MAX_WAIT = ((1 << ID_W) - 1) * TICKS_PER_UNIT;
  localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SLOT_W-1:0] cur;
  logic              is_last;

  assign cur     = slots_i[idx_q];
  assign is_last = (idx_q == LAST);

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    id_d       = id_q;
    cnt_d      = cnt_q;
    tick_clr_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_FETCH;
          idx_d   = '0;
        end
      end
      ST_FETCH: begin
        if (cur == '0) begin
          state_d = ST_IDLE;
        end else if (cur[SLOT_W-1]) begin
          if (cur[ID_W-1:0] == '0) begin
            // zero-length pause: step on
            if (is_last) state_d = ST_IDLE;
            else         idx_d   = idx_q + IDX_W'(1);
          end else begin
            cnt_d      = CNT_W'(cur[ID_W-1:0]) * CNT_W'(TICKS_PER_UNIT);
            tick_clr_o = 1'b1;
            state_d    = ST_WAIT;
          end
        end else begin
          id_d    = cur[ID_W-1:0];
          state_d = ST_PLAY;
        end
      end
      ST_PLAY: begin
        if (play_done_i) begin
          if (is_last) state_d = ST_IDLE;
          else begin
            idx_d   = idx_q + IDX_W'(1);
            state_d = ST_FETCH;
          end
        end
      end
      ST_WAIT: begin
        if (tick_i) begin
          if (cnt_q == CNT_W'(1)) begin
            if (is_last) state_d = ST_IDLE;
            else begin
              idx_d   = idx_q + IDX_W'(1);
              state_d = ST_FETCH;
            end
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      id_q    <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      id_q    <= id_d;
      cnt_q   <= cnt_d;
    end
  end

  assign play_req_o = (state_q == ST_PLAY);
  assign play_id_o  = id_q;
  assign busy_o     = (state_q != ST_IDLE);
endmodule

// File: rtl/wave_seq.sv
module wave_seq
  import wave_seq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS      = 8,
  parameter int unsigned ADDR_W         = 4,
  parameter int unsigned SLOT_BASE      = 4,
  parameter int unsigned CLK_PER_MS     = 250000,
  parameter int unsigned TICKS_PER_UNIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              play_req_o,
  output logic [6:0]        play_id_o,
  input  logic              play_done_i
);
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] slots;
  logic start, abort, busy, tick, tick_clr;

  wave_seq_regs #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .SLOT_BASE (SLOT_BASE)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .busy_i    (busy),
    .rd_data_o (rd_data_o),
    .slots_o   (slots),
    .start_o   (start),
    .abort_o   (abort)
  );

  wave_seq_tick #(
    .CLK_PER_MS (CLK_PER_MS)
  ) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tick_clr),
    .tick_o (tick)
  );

  wave_seq_fsm #(
    .NUM_SLOTS      (NUM_SLOTS),
    .TICKS_PER_UNIT (TICKS_PER_UNIT)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slots_i     (slots),
    .start_i     (start),
    .abort_i     (abort),
    .tick_i      (tick),
    .play_done_i (play_done_i),
    .tick_clr_o  (tick_clr),
    .play_req_o  (play_req_o),
    .play_id_o   (play_id_o),
    .busy_o      (busy)
  );
endmodule

// File: rtl/wave_seq_chk.sv
module wave_seq_chk #(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned GO_ADDR = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [7:0]        wr_data_i,
  input logic              play_req_o,
  input logic [6:0]        play_id_o,
  input logic              play_done_i,
  input logic              busy_i
);
  logic go_set, go_clr;
  assign go_set = wr_en_i && (wr_addr_i == ADDR_W'(GO_ADDR)) && wr_data_i[0];
  assign go_clr = wr_en_i && (wr_addr_i == ADDR_W'(GO_ADDR)) && !wr_data_i[0];

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && go_set |=> busy_i);

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    play_req_o && !play_done_i && !go_clr |=> play_req_o && $stable(play_id_o));

  p_id_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    play_req_o |-> (play_id_o != 7'd0) && busy_i);

  p_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && go_clr |=> !play_req_o && !busy_i);

  p_go_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    play_req_o && go_set && !play_done_i |=> busy_i && play_req_o);
endmodule

bind wave_seq wave_seq_chk #(
  .ADDR_W  (ADDR_W),
  .GO_ADDR (SLOT_BASE + NUM_SLOTS)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .play_req_o  (play_req_o),
  .play_id_o   (play_id_o),
  .play_done_i (play_done_i),
  .busy_i      (busy)
);

// File: tb/test_wave_seq.sv
`timescale 1ns/1ps
module test_wave_seq;
  localparam int P    = 5;
  localparam int TPU  = 10;
  localparam int GO_A = 12;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [3:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       play_req_o;
  logic [6:0] play_id_o;
  logic       play_done_i = 1'b0;

  always #2 clk_i = ~clk_i;

  wave_seq #(.CLK_PER_MS(P), .TICKS_PER_UNIT(TPU)) i_wave_seq (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .rd_data_o, .play_req_o, .play_id_o, .play_done_i
  );

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  // engine model / monitor state
  bit         stall = 0;
  bit         prev_req = 0, prev_go = 0;
  logic [6:0] prev_id = '0;
  int         lat = 0, gap = 0, id_err = 0, n_got = 0;
  int         got_id [16];
  int         got_gap[16];

  logic [7:0] slot_v[8];
  int         exp_id [8];
  int         exp_gap[8];
  int         n_exp;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = 8'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr_i = 4'(a);
    #1;
    d = int'(rd_data_o);
  endtask

  // walk the slots as the requirements describe
  task automatic model();
    int acc = 0;
    n_exp = 0;
    for (int i = 0; i < 8; i++) begin
      if (slot_v[i] == 8'h00) break;
      if (slot_v[i][7]) begin
        acc += 1 + int'(slot_v[i][6:0]) * TPU * P;
      end else begin
        exp_id[n_exp]  = int'(slot_v[i][6:0]);
        exp_gap[n_exp] = acc + 1;
        n_exp++;
        acc = 0;
      end
    end
  endtask

  task automatic run_seq(input string req);
    int g, t;
    for (int i = 0; i < 8; i++) wr(4 + i, int'(slot_v[i]));
    model();
    rd_addr_i = 4'(GO_A);
    n_got = 0; id_err = 0;
    wr(GO_A, 1);
    t = 0;
    do begin
      @(negedge clk_i);
      t++;
      g = int'(rd_data_o[0]);
    end while (g == 1 && t < 20000);
    check(t < 20000, req, t, 0);
    check(play_req_o == 1'b0, req, int'(play_req_o), 0);
    check(n_got == n_exp, req, n_got, n_exp);
    check(id_err == 0, "R3", id_err, 0);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      check(got_id[i] == exp_id[i], req, got_id[i], exp_id[i]);
      check(got_gap[i] == exp_gap[i], req, got_gap[i], exp_gap[i]);
    end
  endtask

  // playback engine model and monitor
  initial begin
    forever begin
      @(negedge clk_i);
      play_done_i = 1'b0;
      if (!prev_go) gap = 0;
      if (play_req_o && !prev_req) begin
        if (n_got < 16) begin
          got_id[n_got]  = int'(play_id_o);
          got_gap[n_got] = gap;
          n_got++;
        end
        lat = $urandom_range(4);
      end
      if (play_req_o && prev_req && play_id_o != prev_id) id_err++;
      if (!play_req_o) gap++;
      if (play_req_o && !stall) begin
        if (lat == 0) begin
          play_done_i = 1'b1;
          gap = 0;
        end else lat--;
      end
      prev_req = play_req_o;
      prev_id  = play_id_o;
      prev_go  = (rd_addr_i == 4'(GO_A)) ? rd_data_o[0] : 1'b1;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int v, w;
    logic [7:0] keep[8];
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10: reset state
    check(play_req_o == 1'b0, "R10", int'(play_req_o), 0);
    rd(GO_A, v); check(v == 0, "R10", v, 0);
    for (int i = 0; i < 8; i++) begin
      rd(4 + i, v); check(v == 0, "R10", v, 0);
    end

    // R1: slot storage and readback; foreign addresses ignored
    for (int i = 0; i < 8; i++) begin
      keep[i] = 8'($urandom_range(255));
      wr(4 + i, int'(keep[i]));
    end
    wr(3, 8'hFF); wr(13, 8'hFF); wr(0, 8'h5A);
    for (int i = 0; i < 8; i++) begin
      rd(4 + i, v); check(v == int'(keep[i]), "R1", v, int'(keep[i]));
    end
    rd(GO_A, v); check(v == 0, "R1", v, 0);
    check(play_req_o == 1'b0, "R1", int'(play_req_o), 0);

    // R4: stop at first zero slot
    slot_v = '{8'h21, 8'h22, 8'h00, 8'h23, 8'h24, 8'h25, 8'h26, 8'h27};
    run_seq("R4");
    // R5: all eight slots played
    slot_v = '{8'h01, 8'h7F, 8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15};
    run_seq("R5");
    // R7: zero-length pause
    slot_v = '{8'h80, 8'h05, 8'h80, 8'h80, 8'h06, 8'h00, 8'h00, 8'h00};
    run_seq("R7");
    // R6: timed pauses
    slot_v = '{8'h82, 8'h07, 8'h81, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00};
    run_seq("R6");
    // R2: slot 0 zero -> run ends at once
    slot_v = '{8'h00, 8'h33, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    run_seq("R2");

    // R8/R9: start while running, then abort
    slot_v = '{8'h11, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    for (int i = 0; i < 8; i++) wr(4 + i, int'(slot_v[i]));
    stall = 1;
    rd_addr_i = 4'(GO_A);
    wr(GO_A, 1);
    repeat (4) @(negedge clk_i);
    check(play_req_o == 1'b1 && play_id_o == 7'h11, "R3", int'(play_id_o), 17);
    rd(GO_A, v); check(v == 1, "R2", v, 1);
    wr(GO_A, 1);
    check(play_req_o == 1'b1 && play_id_o == 7'h11, "R9", int'(play_id_o), 17);
    rd(GO_A, v); check(v == 1, "R9", v, 1);
    wr(GO_A, 0);
    check(play_req_o == 1'b0, "R8", int'(play_req_o), 0);
    rd(GO_A, v); check(v == 0, "R8", v, 0);
    stall = 0;
    w = n_got;
    repeat (20) @(negedge clk_i);
    check(n_got == w && play_req_o == 1'b0, "R8", n_got, w);

    // random slot lists
    for (int r = 0; r < 20; r++) begin
      for (int i = 0; i < 8; i++) begin
        v = $urandom_range(99);
        if (v < 60)      slot_v[i] = 8'($urandom_range(127, 1));
        else if (v < 88) slot_v[i] = 8'h80 | 8'($urandom_range(3));
        else             slot_v[i] = 8'h00;
      end
      run_seq("R4");
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule